// File: doc/BRIEF.md
# Serial EEPROM Slave with Read Path and Busy Window

This block is the slave end of a two-wire (I2C) serial EEPROM. It runs from a fast system clock and oversamples the bus: both bus lines pass through synchronisers, and START, STOP and repeated START are detected from the line edges. After a START it matches the device-select byte, loads a two-byte memory address into an internal counter, and serves reads from a small on-chip byte array. The array reads as all ones until it is written. A read can take the byte at the counter (current-address read) or follow a dummy write that loads the counter first (random read).

A single-byte write is included. It exists so that the address load and the busy period that follows a write can be exercised. The byte is committed when the write's STOP arrives, and a cycle counter then models the internal programming time. During that time the slave ignores the bus completely, so a master finds out the write has finished by sending device selects until one is acknowledged. The slave only pulls SDA low. `sdaOe` high means "drive the line to 0", and the line is released at all other times.

Top module: `eeprom_rd_slave`

## Requirements
- R1: After reset, `sdaOe` is 0 and every array location reads 8'hFF.
- R2: A START or repeated START is recognised in any state and returns the slave to the device-select phase with its bit count cleared. This also applies in the middle of a byte. A STOP returns it to idle.
- R3: A device-select byte carries the 7-bit address (DEV_ADDR, default 7'h50) in bits 7:1 and R/W in bit 0, where 1 means read. On a match the slave pulls SDA low for the ninth clock. On a mismatch it stays released until the next START.
- R4: After a write select, two address bytes follow, most significant first. Each is acknowledged. The low ADDR_BITS bits (default 8) of the 15-bit address load the counter, and the higher bits are ignored. A repeated START after them performs a random read from that address.
- R5: A read select is acknowledged, and the byte at the counter is then shifted out MSB first. The counter advances by one for each byte shifted out.
- R6: After each read byte, a master ACK (SDA low on the ninth clock) makes the next byte follow. A NACK makes the slave release SDA and wait for a STOP or START.
- R7: The counter wraps from 2^ADDR_BITS-1 back to 0, for both reads and writes.
- R8: A data byte after the address is acknowledged, and the counter advances past it. The byte is stored at its address only when a STOP follows. A START before that STOP discards the byte, and no busy period starts. Further data bytes are not acknowledged.
- R9: For WRITE_CYCLES clocks after the STOP that commits a write, the slave acknowledges nothing, including its own device select. After that period it responds normally.
- R10: While `writeLock` is 1, a data byte is not acknowledged, the array is unchanged and no busy period starts. Reads behave the same whatever the level of `writeLock`.
- R11: `sdaOe` changes only while SCL is low, and it is 1 only in acknowledge slots and in read data bits whose value is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Asynchronous active-low reset |
| scl | input | 1 | Bus clock line |
| sdaIn | input | 1 | Bus data line as seen on the wire |
| writeLock | input | 1 | 1 blocks writes to the array |
| sdaOe | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The hardest situation to reach is a device select that arrives during the internal write time. It can only be reached through a STOP that ends a complete write sequence, and the window closes after a fixed number of clocks. The bench therefore issues a device select right after each committing STOP and expects a NACK. It then repeats the select until an ACK appears, and requires at least one refusal along the way. Two cases cannot be seen from a single transfer: a write discarded by a repeated START, and a write blocked by `writeLock`. For each, the bench checks that no busy period followed, then reads the location back through a random read.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

  // Strobes from control to datapath, valid for one system clock.
  typedef struct packed {
    logic shiftIn;    // shift rxBit into the receive register
    logic rxBit;      // sampled SDA value
    logic loadHi;     // capture upper address byte
    logic loadLo;     // load address counter from both address bytes
    logic latchData;  // hold write byte, remember its address, advance counter
    logic commit;     // write held byte into the array
    logic loadTx;     // load transmit byte from array, advance counter
    logic shiftTx;    // move next transmit bit to the MSB
  } eeStrobe_t;

  typedef enum logic [2:0] {
    PH_IDLE, PH_RECV, PH_ACK, PH_SEND, PH_MACK
  } ePhase_t;

  typedef enum logic [1:0] {
    K_DEV, K_HI, K_LO, K_DATA
  } eKind_t;

endpackage

// File: rtl/eeprom_datapath.sv
module eeprom_datapath
  import eeprom_pkg::*;
#(
  parameter int ADDR_BITS = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  eeStrobe_t  stb,
  output logic [7:0] rxByte,
  output logic       txMsb
);

  localparam int DEPTH = 1 << ADDR_BITS;
  localparam logic [ADDR_BITS-1:0] LAST_ADDR = ADDR_BITS'(DEPTH - 1);

  logic [7:0]           mem [DEPTH];
  logic [7:0]           rxReg, txReg, holdData;
  logic [6:0]           hiReg;
  logic [ADDR_BITS-1:0] addrCnt, holdAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxReg    <= '0;
      txReg    <= 8'hFF;
      holdData <= '0;
      hiReg    <= '0;
      addrCnt  <= '0;
      holdAddr <= '0;
    end else begin
      if (stb.shiftIn) rxReg <= {rxReg[6:0], stb.rxBit};
      if (stb.loadHi)  hiReg <= rxReg[6:0];
      if (stb.loadLo)  addrCnt <= ADDR_BITS'({hiReg, rxReg});
      if (stb.latchData) begin
        holdData <= rxReg;
        holdAddr <= addrCnt;
        addrCnt  <= addrCnt + 1'b1;
      end
      if (stb.loadTx) begin
        txReg   <= mem[addrCnt];
        addrCnt <= addrCnt + 1'b1;
      end else if (stb.shiftTx) begin
        txReg <= {txReg[6:0], 1'b1};
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (stb.commit) begin
      mem[holdAddr] <= holdData;
    end
  end

  assign rxByte = rxReg;
  assign txMsb  = txReg[7];

  // R7: counter wraps from the last location to zero
  assert_wrap_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((stb.loadTx || stb.latchData) && addrCnt == LAST_ADDR) |=> addrCnt == '0);

  // R4: control never requests two counter updates at once
  assert_one_addr_op_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.loadLo, stb.latchData, stb.loadTx}));

endmodule

// File: rtl/eeprom_ctrl.sv
module eeprom_ctrl
  import eeprom_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR     = 7'h50,
  parameter int         WRITE_CYCLES = 2000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       writeLock,
  input  logic [7:0] rxByte,
  input  logic       txMsb,
  output eeStrobe_t  stb,
  output logic       sdaOe
);

  localparam int CNT_W = $clog2(WRITE_CYCLES + 1);

  logic [1:0] sclSync, sdaSync;
  logic       sclPrev, sdaPrev, sclNow, sdaNow;
  logic       sclRise, sclFall, startSeen, stopSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclPrev <= sclSync[1];
      sdaPrev <= sdaSync[1];
    end
  end

  assign sclNow    = sclSync[1];
  assign sdaNow    = sdaSync[1];
  assign sclRise   = sclNow & ~sclPrev;
  assign sclFall   = ~sclNow & sclPrev;
  assign startSeen = sclNow & sclPrev & sdaPrev & ~sdaNow;
  assign stopSeen  = sclNow & sclPrev & ~sdaPrev & sdaNow;

  ePhase_t    phase, phaseN;
  eKind_t     kind, kindN;
  logic [3:0] bitCnt, bitCntN;
  logic       isRead, isReadN, masterAck, masterAckN;
  logic       wrPending, wrPendingN, startBusy;
  logic [CNT_W-1:0] busyCnt;
  logic       busy;

  assign busy = (busyCnt != '0);

  always_comb begin
    phaseN     = phase;
    kindN      = kind;
    bitCntN    = bitCnt;
    isReadN    = isRead;
    masterAckN = masterAck;
    wrPendingN = wrPending;
    startBusy  = 1'b0;
    stb        = '0;
    stb.rxBit  = sdaNow;
    if (busy) begin
      phaseN     = PH_IDLE;
      wrPendingN = 1'b0;
    end else if (stopSeen) begin
      phaseN = PH_IDLE;
      if (wrPending) begin
        stb.commit = 1'b1;
        startBusy  = 1'b1;
        wrPendingN = 1'b0;
      end
    end else if (startSeen) begin
      phaseN     = PH_RECV;
      kindN      = K_DEV;
      bitCntN    = '0;
      wrPendingN = 1'b0;
    end else begin
      case (phase)
        PH_RECV: begin
          if (sclRise && bitCnt < 4'd8) begin
            stb.shiftIn = 1'b1;
            bitCntN     = bitCnt + 1'b1;
          end else if (sclFall && bitCnt == 4'd8) begin
            case (kind)
              K_DEV: begin
                if (rxByte[7:1] == DEV_ADDR) begin
                  phaseN  = PH_ACK;
                  isReadN = rxByte[0];
                end else begin
                  phaseN = PH_IDLE;
                end
              end
              K_HI: begin
                stb.loadHi = 1'b1;
                phaseN     = PH_ACK;
              end
              K_LO: begin
                stb.loadLo = 1'b1;
                phaseN     = PH_ACK;
              end
              default: begin
                if (!writeLock) begin
                  stb.latchData = 1'b1;
                  wrPendingN    = 1'b1;
                  phaseN        = PH_ACK;
                end else begin
                  phaseN = PH_IDLE;
                end
              end
            endcase
          end
        end
        PH_ACK: begin
          if (sclFall) begin
            bitCntN = '0;
            case (kind)
              K_DEV: begin
                if (isRead) begin
                  phaseN     = PH_SEND;
                  stb.loadTx = 1'b1;
                end else begin
                  phaseN = PH_RECV;
                  kindN  = K_HI;
                end
              end
              K_HI: begin
                phaseN = PH_RECV;
                kindN  = K_LO;
              end
              K_LO: begin
                phaseN = PH_RECV;
                kindN  = K_DATA;
              end
              default: phaseN = PH_IDLE;
            endcase
          end
        end
        PH_SEND: begin
          if (sclFall) begin
            if (bitCnt == 4'd7) begin
              phaseN  = PH_MACK;
              bitCntN = '0;
            end else begin
              stb.shiftTx = 1'b1;
              bitCntN     = bitCnt + 1'b1;
            end
          end
        end
        PH_MACK: begin
          if (sclRise) masterAckN = ~sdaNow;
          if (sclFall) begin
            if (masterAck) begin
              phaseN     = PH_SEND;
              stb.loadTx = 1'b1;
              bitCntN    = '0;
            end else begin
              phaseN = PH_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      kind      <= K_DEV;
      bitCnt    <= '0;
      isRead    <= 1'b0;
      masterAck <= 1'b0;
      wrPending <= 1'b0;
      busyCnt   <= '0;
    end else begin
      phase     <= phaseN;
      kind      <= kindN;
      bitCnt    <= bitCntN;
      isRead    <= isReadN;
      masterAck <= masterAckN;
      wrPending <= wrPendingN;
      if (startBusy)   busyCnt <= CNT_W'(WRITE_CYCLES);
      else if (busy)   busyCnt <= busyCnt - 1'b1;
    end
  end

  assign sdaOe = (phase == PH_ACK) | ((phase == PH_SEND) & ~txMsb);

  // R11: the slave only moves SDA while the synchronised SCL is low
  assert_sda_scl_low_R11: assert property (@(posedge clk) disable iff (!rstN)
    (sdaOe != $past(sdaOe)) |-> !sclNow);

  // R9: nothing is driven while the write timer runs
  assert_busy_silent_R9: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !sdaOe);

  // R8: a fresh busy window only opens from a committed write
  assert_busy_from_commit_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(stb.commit));

endmodule

// File: rtl/eeprom_rd_slave.sv
module eeprom_rd_slave
  import eeprom_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR     = 7'h50,
  parameter int         ADDR_BITS    = 8,
  parameter int         WRITE_CYCLES = 2000
) (
  input  logic clk,
  input  logic rstN,
  input  logic scl,
  input  logic sdaIn,
  input  logic writeLock,
  output logic sdaOe
);

  eeStrobe_t  stb;
  logic [7:0] rxByte;
  logic       txMsb;

  eeprom_ctrl #(
    .DEV_ADDR     (DEV_ADDR),
    .WRITE_CYCLES (WRITE_CYCLES)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .sclIn     (scl),
    .sdaIn     (sdaIn),
    .writeLock (writeLock),
    .rxByte    (rxByte),
    .txMsb     (txMsb),
    .stb       (stb),
    .sdaOe     (sdaOe)
  );

  eeprom_datapath #(
    .ADDR_BITS (ADDR_BITS)
  ) uData (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .rxByte (rxByte),
    .txMsb  (txMsb)
  );

endmodule

// File: tb/tb_eeprom_rd_slave.sv
`timescale 1ns/1ps
module tb_eeprom_rd_slave;

  localparam int Q = 10;
  localparam int WCYC = 1500;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic mSda = 1'b1;
  logic writeLock = 1'b0;
  logic sdaOe;
  wire  busSda = mSda & ~sdaOe;

  always #2.5 clk = ~clk;

  eeprom_rd_slave #(.WRITE_CYCLES(WCYC)) dut (
    .clk(clk), .rstN(rstN), .scl(scl), .sdaIn(busSda),
    .writeLock(writeLock), .sdaOe(sdaOe)
  );

  int nChecks = 0;
  int nFail = 0;
  int sclViol = 0;
  bit done = 0;

  logic [7:0] expQ[$];
  string      tagQ[$];
  logic [7:0] rdVal;
  event       rdEv;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @rdEv;
      if (expQ.size() == 0) check(0, "unexpected read byte", rdVal, 0);
      else begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(rdVal == e, t, rdVal, e);
      end
    end
  end

  // R11 observed at the pins
  logic prevOe = 1'b0;
  always @(negedge clk) begin
    if (rstN && sdaOe !== prevOe && scl) sclViol++;
    prevOe <= sdaOe;
  end

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2cStart();
    mSda = 1'b1; waitQ(); scl = 1'b1; waitQ();
    mSda = 1'b0; waitQ(); scl = 1'b0; waitQ();
  endtask

  task automatic i2cStop();
    mSda = 1'b0; waitQ(); scl = 1'b1; waitQ();
    mSda = 1'b1; waitQ();
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      mSda = b[i]; waitQ(); scl = 1'b1; waitQ(); waitQ(); scl = 1'b0; waitQ();
    end
  endtask

  task automatic sendByte(input logic [7:0] b, output bit ack);
    sendBits(b, 8);
    mSda = 1'b1; waitQ(); scl = 1'b1; waitQ();
    ack = (busSda == 1'b0);
    waitQ(); scl = 1'b0; waitQ();
  endtask

  task automatic expectRead(input logic [7:0] e, input string tag);
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  task automatic readByte(input bit giveAck);
    logic [7:0] d = '0;
    for (int i = 0; i < 8; i++) begin
      mSda = 1'b1; waitQ(); scl = 1'b1; waitQ();
      d = {d[6:0], busSda};
      waitQ(); scl = 1'b0; waitQ();
    end
    rdVal = d;
    -> rdEv;
    mSda = giveAck ? 1'b0 : 1'b1; waitQ(); scl = 1'b1; waitQ(); waitQ();
    scl = 1'b0; waitQ(); mSda = 1'b1;
  endtask

  // dummy write to load the counter, then read select
  task automatic setAddr(input logic [7:0] hi, input logic [7:0] lo, input string tag);
    bit a;
    i2cStart();
    sendByte(8'hA0, a); check(a, {tag, " select write ack"}, a, 1);
    sendByte(hi, a);    check(a, {tag, " hi addr ack R4"}, a, 1);
    sendByte(lo, a);    check(a, {tag, " lo addr ack R4"}, a, 1);
    i2cStart();
    sendByte(8'hA1, a); check(a, {tag, " select read ack R3"}, a, 1);
  endtask

  // write one byte then wait for the busy window to end
  task automatic writeByte(input logic [7:0] hi, input logic [7:0] lo, input logic [7:0] d);
    bit a;
    int tries = 0;
    i2cStart();
    sendByte(8'hA0, a); check(a, "R3 write select ack", a, 1);
    sendByte(hi, a);    check(a, "R4 hi addr ack", a, 1);
    sendByte(lo, a);    check(a, "R4 lo addr ack", a, 1);
    sendByte(d, a);     check(a, "R8 data ack", a, 1);
    i2cStop();
    a = 0;
    while (!a && tries < 40) begin
      i2cStart();
      sendByte(8'hA0, a);
      i2cStop();
      tries++;
    end
    check(tries > 1, "R9 first poll after write refused", tries, 2);
    check(a, "R9 device answers after write time", a, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    bit a;
    repeat (5) @(negedge clk);
    check(sdaOe == 1'b0, "R1 reset releases SDA", sdaOe, 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R1: blank array reads FF
    setAddr(8'h00, 8'h10, "R1");
    expectRead(8'hFF, "R1 blank location");
    readByte(0); i2cStop();

    // R3: other device address is ignored
    i2cStart(); sendByte(8'hA2, a); i2cStop();
    check(!a, "R3 mismatched select not acked", a, 0);

    // R8/R9: two writes with busy polling
    writeByte(8'h00, 8'h10, 8'h5A);
    writeByte(8'h00, 8'h11, 8'h3C);

    // R4: upper address bits ignored, random read
    setAddr(8'h7F, 8'h10, "R4");
    expectRead(8'h5A, "R4 random read ignores upper bits");
    readByte(0); i2cStop();

    // R5: current-address reads follow the counter
    i2cStart(); sendByte(8'hA1, a); check(a, "R5 current read select ack", a, 1);
    expectRead(8'h3C, "R5 current read after 0x10");
    readByte(0); i2cStop();
    i2cStart(); sendByte(8'hA1, a);
    expectRead(8'hFF, "R5 counter moved to 0x12");
    readByte(0); i2cStop();

    // R6: sequential read with master ACKs
    setAddr(8'h00, 8'h10, "R6");
    expectRead(8'h5A, "R6 seq byte 0");
    readByte(1);
    expectRead(8'h3C, "R6 seq byte 1");
    readByte(1);
    expectRead(8'hFF, "R6 seq byte 2");
    readByte(0);
    i2cStop();

    // R7: wrap from last location to zero
    writeByte(8'h00, 8'hFF, 8'h77);
    writeByte(8'h00, 8'h00, 8'h21);
    setAddr(8'h00, 8'hFF, "R7");
    expectRead(8'h77, "R7 last location");
    readByte(1);
    expectRead(8'h21, "R7 wrapped to zero");
    readByte(0); i2cStop();

    // R10: write blocked, read still works
    writeLock = 1'b1;
    i2cStart();
    sendByte(8'hA0, a); sendByte(8'h00, a); sendByte(8'h10, a);
    sendByte(8'h99, a); check(!a, "R10 data refused while locked", a, 0);
    i2cStop();
    i2cStart(); sendByte(8'hA0, a); i2cStop();
    check(a, "R10 no busy after locked write", a, 1);
    setAddr(8'h00, 8'h10, "R10");
    expectRead(8'h5A, "R10 locked read unchanged data");
    readByte(0); i2cStop();
    writeLock = 1'b0;

    // R2: repeated START in the middle of a byte
    i2cStart(); sendBits(8'hA0, 3);
    setAddr(8'h00, 8'h11, "R2");
    expectRead(8'h3C, "R2 read after mid-byte restart");
    readByte(0); i2cStop();

    // R8: repeated START discards a pending write
    i2cStart();
    sendByte(8'hA0, a); sendByte(8'h00, a); sendByte(8'h20, a);
    sendByte(8'h55, a); check(a, "R8 data acked before abort", a, 1);
    i2cStart(); sendByte(8'hA1, a);
    expectRead(8'hFF, "R8 counter past aborted byte");
    readByte(0); i2cStop();
    i2cStart(); sendByte(8'hA0, a); i2cStop();
    check(a, "R8 no busy after aborted write", a, 1);
    setAddr(8'h00, 8'h20, "R8");
    expectRead(8'hFF, "R8 aborted byte not stored");
    readByte(0); i2cStop();

    repeat (20) @(negedge clk);
    check(expQ.size() == 0, "scoreboard drained", expQ.size(), 0);
    check(sclViol == 0, "R11 SDA moved while SCL high", sclViol, 0);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule